// File: doc/BRIEF.md
# Delay-Locked Loop Lock Tracker

This block follows the lock state of the delay-locked loop that recovers the memory clock. It does not model the delay line or the phase detector. It watches the incoming memory clock from a free-running, faster reference clock and reports whether the loop may be treated as locked. It also reports when the loop is switched off and bypassed. Lock is earned by counting input clock cycles whose period is short enough. A single period that is too long, or a clock that goes silent, throws that credit away. The count then starts again by itself, with no reset pulse needed.

The memory clock is first divided by a power of two in its own domain. This lets a reference clock only a few times faster than the divided clock sample it safely. The divided clock passes through a two-flop synchronizer, and the period between its rising edges is measured in reference ticks. Each good divided period credits 2^DIV_LOG2 input clock cycles toward the lock target. With the enable pin low the tracker sits in bypass.

The defaults assume a 400 MHz reference clock and divide by four. The 80 MHz floor of the loop's operating range then becomes a divided period of 20 ticks. A silence of 32 ticks, about 30 ns longer than the slowest legal divided period, counts as a stopped clock.

Top module: `dll_lock_tracker`

## Requirements
- R1: While rstN is low, and in the first cycle after it rises, locked and bypass are both 0.
- R2: When enableIn is sampled low on a refClk rising edge, bypass is 1 and locked is 0 from that edge on, for as long as enableIn stays low, whatever memClk does.
- R3: When enableIn returns high, bypass drops on the next refClk edge and locked stays 0 until a complete new lock sequence (R4) has been counted.
- R4: locked rises once ceil(LOCK_CYCLES / 2^DIV_LOG2) consecutive good divided edges have been counted. A good divided edge is a rising edge of the divided clock whose period since the previous divided rising edge is at most SLOW_TICKS reference ticks. The first divided edge after reset or after a stop is never good.
- R5: A divided rising edge whose period exceeds SLOW_TICKS clears the accumulated count and drops locked. It is not itself counted.
- R6: When no divided rising edge has been seen for STOP_TICKS reference ticks, locked drops and the count clears without waiting for another edge.
- R7: locked rises on the third refClk rising edge after the divided clock rises at the synchronizer input, one edge per synchronizer flop plus the edge that updates the state.
- R8: After a stop, once memClk resumes at a good rate, locked returns by itself after a full count, with no reset.
- R9: Periods are measured on memClk divided by 2^DIV_LOG2. A memClk period that is good by itself but gives a divided period above SLOW_TICKS never locks.
- R10: A divided period of exactly SLOW_TICKS ticks counts as good and does not drop lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Free-running reference clock; all tracking logic runs on it |
| rstN | input | 1 | Active-low asynchronous reset for both the reference logic and the divider |
| memClk | input | 1 | Incoming memory clock being watched |
| enableIn | input | 1 | Loop enable strap, sampled on refClk; low selects bypass |
| locked | output | 1 | High while the loop is considered locked |
| bypass | output | 1 | High while the loop is disabled |

## Verification
The bench builds the tracker with LOCK_CYCLES = 16, DIV_LOG2 = 1, SLOW_TICKS = 12 and STOP_TICKS = 24. Lock therefore takes eight good divided edges, a few hundred reference ticks instead of thousands. With memClk half-periods of only two to four ticks the bench can land a divided period exactly on the slowness limit, one tick over it, and past the stop limit. Divide-by-two also allows a memClk period of seven ticks, legal when undivided, whose fourteen-tick divided period must keep the loop from locking.

// File: rtl/dll_trk_pkg.sv
package dll_trk_pkg;

  typedef enum logic [1:0] {
    ST_BYPASS  = 2'd0,
    ST_ACQUIRE = 2'd1,
    ST_LOCKED  = 2'd2
  } trkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearStable;
    logic incStable;
  } trkStrobe_t;

  // observations from datapath to control
  typedef struct packed {
    logic edgePulse;  // synchronized rising edge of the divided clock
    logic slowEdge;   // measured period above the slowness limit
    logic stopDet;    // silence reached the stop limit
    logic nearFull;   // one more credit reaches the lock target
  } trkStatus_t;

endpackage

// File: rtl/dll_trk_prescale.sv
module dll_trk_prescale #(
  parameter int DIV_LOG2 = 2
) (
  input  logic memClk,
  input  logic rstN,
  output logic divClk
);

  generate
    if (DIV_LOG2 == 0) begin : g_pass
      assign divClk = memClk;
    end else begin : g_div
      logic [DIV_LOG2-1:0] preCnt;

      always_ff @(posedge memClk or negedge rstN) begin
        if (!rstN) preCnt <= '0;
        else       preCnt <= preCnt + 1'b1;
      end

      assign divClk = preCnt[DIV_LOG2-1];
    end
  endgenerate

endmodule

// File: rtl/dll_trk_datapath.sv
module dll_trk_datapath
  import dll_trk_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024,
  parameter int STEP        = 4,
  parameter int SLOW_TICKS  = 20,
  parameter int STOP_TICKS  = 32
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       divClk,
  input  trkStrobe_t strobe,
  output trkStatus_t status
);

  localparam int PW = $clog2(STOP_TICKS + 1);
  localparam int SW = $clog2(LOCK_CYCLES + STEP + 1);
  localparam logic [PW-1:0] STOP_V = PW'(STOP_TICKS);
  localparam logic [PW-1:0] SLOW_V = PW'(SLOW_TICKS);
  localparam logic [SW-1:0] STEP_V = SW'(STEP);
  localparam logic [SW:0]   LOCK_V = (SW+1)'(LOCK_CYCLES);

  // [0],[1] synchronizer, [2] previous synchronized level
  logic [2:0]    syncQ;
  logic [PW-1:0] periodCnt;
  logic [SW-1:0] stableCnt;
  logic [SW:0]   creditSum;
  logic          edgeNow;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], divClk};
  end

  assign edgeNow = syncQ[1] & ~syncQ[2];

  // ticks since the last edge; starts saturated so the first edge is not credited
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                  periodCnt <= STOP_V;
    else if (edgeNow)           periodCnt <= '0;
    else if (periodCnt < STOP_V) periodCnt <= periodCnt + 1'b1;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                   stableCnt <= '0;
    else if (strobe.clearStable) stableCnt <= '0;
    else if (strobe.incStable)   stableCnt <= stableCnt + STEP_V;
  end

  assign creditSum = {1'b0, stableCnt} + {1'b0, STEP_V};

  always_comb begin
    status.edgePulse = edgeNow;
    status.slowEdge  = (periodCnt >= SLOW_V);
    status.stopDet   = (periodCnt == STOP_V);
    status.nearFull  = (creditSum >= LOCK_V);
  end

  AST_INC_ON_EDGE: assert property (@(posedge refClk) disable iff (!rstN)
    strobe.incStable |-> edgeNow); // R4

endmodule

// File: rtl/dll_trk_ctrl.sv
module dll_trk_ctrl
  import dll_trk_pkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  logic       enableIn,
  input  trkStatus_t status,
  output trkStrobe_t strobe,
  output logic       locked,
  output logic       bypass
);

  trkState_e stateQ, stateD;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) stateQ <= ST_ACQUIRE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (!enableIn) begin
      stateD             = ST_BYPASS;
      strobe.clearStable = 1'b1;
    end else if (stateQ == ST_BYPASS) begin
      stateD             = ST_ACQUIRE;
      strobe.clearStable = 1'b1;
    end else if (status.stopDet || (status.edgePulse && status.slowEdge)) begin
      stateD             = ST_ACQUIRE;
      strobe.clearStable = 1'b1;
    end else if (status.edgePulse && stateQ == ST_ACQUIRE) begin
      strobe.incStable = 1'b1;
      if (status.nearFull) stateD = ST_LOCKED;
    end
  end

  assign locked = (stateQ == ST_LOCKED);
  assign bypass = (stateQ == ST_BYPASS);

  AST_DISABLE_BYPASS: assert property (@(posedge refClk) disable iff (!rstN)
    !enableIn |=> (bypass && !locked)); // R2

  AST_BYPASS_EXIT: assert property (@(posedge refClk) disable iff (!rstN)
    (enableIn && bypass) |=> (!bypass && !locked)); // R3

  AST_STOP_UNLOCK: assert property (@(posedge refClk) disable iff (!rstN)
    status.stopDet |=> !locked); // R6

  AST_SLOW_UNLOCK: assert property (@(posedge refClk) disable iff (!rstN)
    (status.edgePulse && status.slowEdge) |=> !locked); // R5

  AST_LOCK_ON_EDGE: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(locked) |-> $past(status.edgePulse)); // R4

endmodule

// File: rtl/dll_lock_tracker.sv
module dll_lock_tracker
  import dll_trk_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024,
  parameter int DIV_LOG2    = 2,
  parameter int SLOW_TICKS  = 20,
  parameter int STOP_TICKS  = 32
) (
  input  logic refClk,
  input  logic rstN,
  input  logic memClk,
  input  logic enableIn,
  output logic locked,
  output logic bypass
);

  localparam int STEP = 1 << DIV_LOG2;

  logic       divClk;
  trkStrobe_t strobe;
  trkStatus_t status;

  dll_trk_prescale #(
    .DIV_LOG2 (DIV_LOG2)
  ) prescale_i (
    .memClk (memClk),
    .rstN   (rstN),
    .divClk (divClk)
  );

  dll_trk_datapath #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .STEP        (STEP),
    .SLOW_TICKS  (SLOW_TICKS),
    .STOP_TICKS  (STOP_TICKS)
  ) datapath_i (
    .refClk (refClk),
    .rstN   (rstN),
    .divClk (divClk),
    .strobe (strobe),
    .status (status)
  );

  dll_trk_ctrl ctrl_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .enableIn (enableIn),
    .status   (status),
    .strobe   (strobe),
    .locked   (locked),
    .bypass   (bypass)
  );

endmodule

// File: tb/dll_lock_tracker_tb_top.sv
`timescale 1ns/1ps
module dll_lock_tracker_tb_top;

  localparam int LOCK = 16;
  localparam int DIV  = 1;
  localparam int SLOW = 12;
  localparam int STOP = 24;
  localparam int STEP = 1 << DIV;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic memClk = 1'b0;
  logic enableIn = 1'b1;
  logic locked, bypass;

  always #2.5 refClk = ~refClk;

  dll_lock_tracker #(
    .LOCK_CYCLES (LOCK),
    .DIV_LOG2    (DIV),
    .SLOW_TICKS  (SLOW),
    .STOP_TICKS  (STOP)
  ) dut_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .memClk   (memClk),
    .enableIn (enableIn),
    .locked   (locked),
    .bypass   (bypass)
  );

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    running = 0;
  bit    done = 0;
  int    riseCount = 0;
  int    refCyc = 0;
  int    divRiseCyc = 0;
  int    lockDelta = -1;
  logic  prevLocked = 1'b0;

  // behavioural reference: 0 bypass, 1 acquiring, 2 locked
  int mState = 1;
  int mStable = 0;
  int lastEdge = -1;
  int cyc = 0;
  bit h1, h2, h3;

  function automatic bit divLevel(int n);
    return bit'((n >> (DIV - 1)) & 1);
  endfunction

  always @(posedge refClk) begin
    refCyc++;
    if (!rstN) begin
      mState = 1; mStable = 0; lastEdge = -1; cyc = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      int  gap;
      bit  edgeSeen;
      cyc++;
      edgeSeen = h2 && !h3;
      gap = (lastEdge < 0) ? (1 << 30) : (cyc - 1 - lastEdge);
      if (!enableIn) begin
        mState = 0; mStable = 0;
      end else if (mState == 0) begin
        mState = 1; mStable = 0;
      end else if (gap >= STOP || (edgeSeen && gap >= SLOW)) begin
        mState = 1; mStable = 0;
      end else if (edgeSeen && mState == 1) begin
        mStable += STEP;
        if (mStable >= LOCK) mState = 2;
      end
      if (edgeSeen) lastEdge = cyc;
      h3 = h2; h2 = h1; h1 = divLevel(riseCount);
    end
  end

  // per-cycle comparison against the reference
  always @(negedge refClk) begin
    if (running && !done) begin
      checks++;
      if (locked !== (mState == 2) || bypass !== (mState == 0)) begin
        errors++;
        $display("FAIL %s per-cycle: locked=%0b bypass=%0b expected locked=%0b bypass=%0b",
                 curReq, locked, bypass, (mState == 2), (mState == 0));
      end
    end
    if (!prevLocked && locked === 1'b1 && lockDelta < 0) lockDelta = refCyc - divRiseCyc;
    prevLocked = locked;
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic chkInt(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // n memClk cycles, hi ticks high and lo ticks low each; call at a negedge
  task automatic memCycles(int n, int hi, int lo);
    for (int i = 0; i < n; i++) begin
      memClk = 1'b1;
      riseCount++;
      if (divLevel(riseCount) && !divLevel(riseCount - 1)) divRiseCyc = refCyc;
      repeat (hi) @(negedge refClk);
      memClk = 1'b0;
      repeat (lo) @(negedge refClk);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge refClk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL %s watchdog expired: actual hung expected finished", curReq);
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    enableIn = 1'b1;
    repeat (4) @(negedge refClk);
    running = 1;
    curReq = "R1";
    chk("R1", "locked in reset", locked, 1'b0);
    chk("R1", "bypass in reset", bypass, 1'b0);
    rstN = 1'b1;
    @(negedge refClk);
    chk("R1", "locked after reset", locked, 1'b0);
    chk("R1", "bypass after reset", bypass, 1'b0);

    curReq = "R4";
    memCycles(8, 2, 2);
    chk("R4", "locked before full count", locked, 1'b0);
    memCycles(10, 2, 2);
    chk("R4", "locked after full count", locked, 1'b1);
    chkInt("R7", "ticks from divided rise to lock", lockDelta, 3);

    curReq = "R10";
    memCycles(10, 3, 3);
    chk("R10", "locked at boundary period", locked, 1'b1);

    curReq = "R5";
    memCycles(1, 3, 4);
    memCycles(2, 3, 3);
    chk("R5", "locked after slow period", locked, 1'b0);
    memCycles(10, 3, 3);
    memCycles(1, 3, 4);
    memCycles(10, 3, 3);
    chk("R5", "count cleared by slow period", locked, 1'b0);
    memCycles(20, 3, 3);
    chk("R5", "relock after slow period", locked, 1'b1);

    curReq = "R6";
    repeat (STOP + 10) @(negedge refClk);
    chk("R6", "locked after clock stop", locked, 1'b0);

    curReq = "R8";
    memCycles(20, 2, 2);
    chk("R8", "relock without reset", locked, 1'b1);

    curReq = "R2";
    enableIn = 1'b0;
    @(negedge refClk);
    chk("R2", "bypass when disabled", bypass, 1'b1);
    chk("R2", "locked when disabled", locked, 1'b0);
    memCycles(20, 2, 2);
    chk("R2", "bypass held with clock running", bypass, 1'b1);
    chk("R2", "locked held low with clock running", locked, 1'b0);

    curReq = "R3";
    enableIn = 1'b1;
    @(negedge refClk);
    chk("R3", "bypass after enable", bypass, 1'b0);
    chk("R3", "locked after enable", locked, 1'b0);
    memCycles(8, 2, 2);
    chk("R3", "locked during recount", locked, 1'b0);
    memCycles(12, 2, 2);
    chk("R3", "locked after recount", locked, 1'b1);

    curReq = "R9";
    memCycles(30, 3, 4);
    chk("R9", "locked with slow divided period", locked, 1'b0);
    chk("R9", "bypass with slow divided period", bypass, 1'b0);
    memCycles(20, 2, 3);
    chk("R9", "locked with good divided period", locked, 1'b1);

    @(negedge refClk);
    running = 0;
    done = 1;
    summary();
    $finish;
  end

endmodule